// File: doc/BRIEF.md
# Memory Tag Check Unit

The unit sits on the data-access path of a processor core. For every access it receives the full 64-bit tagged pointer, the current privilege level, the control words of every level, the top-byte-ignore enables for the two address halves and the result of a tag-storage lookup. It returns the address with the tag byte stripped or extended, and it decides whether the access is checked against memory at all.

A checked access compares a 4-bit logical tag with the stored memory tag. The logical tag is taken from the pointer with a carry in from bit 55. When the tags differ, the fault mode of the current level decides what happens. The block can raise a synchronous fault, which carries a status code and the original pointer. It can instead set a sticky flag for the current level and the address half in use. Otherwise nothing happens. Software clears the sticky flags through a separate port.

The result appears one clock after the request.

Top module: `tag_check_unit`

## Requirements
- R1: The logical tag is ((ptr + 2^55) >> 56) mod 16, that is bits [59:56] plus the carry from bit 55.
- R2: When `in_zero_exempt` is 1 and the logical tag is 0, the access is unchecked: no fault and no flag change.
- R3: When `in_tag_hit` is 0 (no tag storage), the access is unchecked: no fault and no flag change.
- R4: At levels 2 and 3, `out_addr` is ptr[55:0] zero-extended, the access is always eligible for checking, and the range index is 0.
- R5: At levels 0 and 1, the range index is ptr[55], and `in_tbi_en[idx]` enables that range (bit 0 is range 0, bit 1 is range 1). When the enable is 0, `out_addr` equals the pointer and the access is unchecked.
- R6: At levels 0 and 1 with the range enable set, `out_addr` is ptr[55:0] sign-extended from bit 55.
- R7: The fault mode is bits [39:38] of level 1's control word when running at level 0. At levels 1 to 3 it is bits [41:40] of that level's own control word. Control word L sits at `in_ctl[L*64 +: 64]`.
- R8: A mismatch in mode 1 gives a one-cycle `out_fault`, `out_fsc` = 0x11 and `out_far` = the original pointer. In all other cases `out_fsc` and `out_far` are 0.
- R9: A mismatch in mode 2 sets `async_flags[level*2 + idx]`. No other flag bit changes.
- R10: A mismatch in mode 0 or mode 3 gives no fault and no flag change. The address is still returned.
- R11: `out_valid`, `out_addr`, `out_fault`, `out_fsc` and `out_far` reflect the request accepted at the previous clock edge. Flag updates land at that same edge.
- R12: `clr_valid` clears the flags of `clr_level` selected by `clr_mask`. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_ptr | input | 64 | Tagged pointer |
| in_level | input | 2 | Current privilege level |
| in_tbi_en | input | 2 | Top-byte-ignore enable per range (range1:range0) |
| in_zero_exempt | input | 1 | Tag 0 matches all |
| in_ctl | input | 256 | Control words of levels 0 to 3 |
| in_tag_hit | input | 1 | Tag storage present |
| in_mem_tag | input | 4 | Stored memory tag |
| clr_valid | input | 1 | Flag clear strobe |
| clr_level | input | 2 | Level whose flags are cleared |
| clr_mask | input | 2 | Range bits to clear |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Cleaned address |
| out_fault | output | 1 | Synchronous tag fault pulse |
| out_fsc | output | 6 | Fault status code |
| out_far | output | 64 | Fault address |
| async_flags | output | 8 | Sticky flags, level*2 + range |

## Verification
The bench builds the unit with its defaults: four levels and 64-bit control words. With these values every level is reachable, including the level-0 path that borrows level 1's field at bits [39:38]. All eight sticky bits can be set and cleared. Pointers are chosen with bit 55 set under tag fields of 0xF and 0x3, so the carry wraps to 0 and steps to 4. The same cycle also carries a set and a clear aimed at one flag bit.

// File: rtl/tag_check_pkg.sv
package tag_check_pkg;
    localparam int ADDR_W    = 64;
    localparam int TAG_W     = 4;
    localparam int TAG_LSB   = 56;
    localparam int CARRY_BIT = 55;
    localparam int NUM_RANGE = 2;
    localparam int MODE_LSB      = 40;
    localparam int MODE_EL0_LSB  = 38;
    localparam int MODE_EL0_SRC  = 1;
    localparam logic [5:0] FSC_TAG = 6'h11;

    typedef enum logic [1:0] {
        FM_IGNORE = 2'd0,
        FM_SYNC   = 2'd1,
        FM_ASYNC  = 2'd2,
        FM_RSVD   = 2'd3
    } fault_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] clean;
        logic              sel;
        logic              strip;
        logic [TAG_W-1:0]  ptag;
    } decode_t;

    function automatic logic [TAG_W-1:0] logical_tag(input logic [ADDR_W-1:0] p);
        logic [TAG_W-1:0] field;
        field = p[TAG_LSB +: TAG_W];
        return field + {{(TAG_W-1){1'b0}}, p[CARRY_BIT]};
    endfunction
endpackage

// File: rtl/tag_ptr_decode.sv
module tag_ptr_decode
    import tag_check_pkg::*;
(
    input  logic [ADDR_W-1:0] ptr,
    input  logic              dual,
    input  logic [1:0]        tbi_en,
    output decode_t           dec
);
    localparam int HI_W = ADDR_W - TAG_LSB;

    always_comb begin
        dec.ptag  = logical_tag(ptr);
        dec.sel   = dual ? ptr[CARRY_BIT] : 1'b0;
        dec.strip = dual ? tbi_en[dec.sel] : 1'b1;
        if (!dual)
            dec.clean = {{HI_W{1'b0}}, ptr[TAG_LSB-1:0]};
        else if (dec.strip)
            dec.clean = {{HI_W{ptr[CARRY_BIT]}}, ptr[TAG_LSB-1:0]};
        else
            dec.clean = ptr;
    end
endmodule

// File: rtl/tag_fault_policy.sv
module tag_fault_policy
    import tag_check_pkg::*;
#(
    parameter int NUM_LVL = 4,
    parameter int CTL_W   = 64,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic [LVL_W-1:0]       level,
    input  logic [NUM_LVL*CTL_W-1:0] ctl,
    input  logic                   strip,
    input  logic [TAG_W-1:0]       ptag,
    input  logic                   zero_exempt,
    input  logic                   tag_hit,
    input  logic [TAG_W-1:0]       mem_tag,
    output fault_mode_e            mode,
    output logic                   sync_fault,
    output logic                   async_set
);
    logic checked, mismatch;

    always_comb begin
        if (level == '0)
            mode = fault_mode_e'(ctl[MODE_EL0_SRC*CTL_W + MODE_EL0_LSB +: 2]);
        else
            mode = fault_mode_e'(ctl[int'(level)*CTL_W + MODE_LSB +: 2]);
        checked    = strip && tag_hit && !(zero_exempt && ptag == '0);
        mismatch   = checked && (ptag != mem_tag);
        sync_fault = mismatch && (mode == FM_SYNC);
        async_set  = mismatch && (mode == FM_ASYNC);
    end
endmodule

// File: rtl/tag_async_status.sv
module tag_async_status
    import tag_check_pkg::*;
#(
    parameter int NUM_LVL = 4,
    localparam int LVL_W  = $clog2(NUM_LVL),
    localparam int FLAG_W = NUM_LVL * NUM_RANGE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_en,
    input  logic [LVL_W-1:0]     set_level,
    input  logic                 set_sel,
    input  logic                 clr_valid,
    input  logic [LVL_W-1:0]     clr_level,
    input  logic [NUM_RANGE-1:0] clr_mask,
    output logic [FLAG_W-1:0]    flags
);
    logic [FLAG_W-1:0] set_vec, clr_vec;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar r = 0; r < NUM_RANGE; r++) begin : g_rng
            assign set_vec[l*NUM_RANGE+r] = set_en && (set_level == LVL_W'(l)) && (set_sel == r[0]);
            assign clr_vec[l*NUM_RANGE+r] = clr_valid && (clr_level == LVL_W'(l)) && clr_mask[r];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_vec) | set_vec;
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_chk
        // R9
        flag_set_chk: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> flags[i]);
        // R12
        flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(flags[i]) |-> $past(clr_vec[i]));
    end
endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit
    import tag_check_pkg::*;
#(
    parameter int NUM_LVL = 4,
    parameter int CTL_W   = 64,
    localparam int LVL_W  = $clog2(NUM_LVL),
    localparam int FLAG_W = NUM_LVL * NUM_RANGE
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [ADDR_W-1:0]        in_ptr,
    input  logic [LVL_W-1:0]         in_level,
    input  logic [NUM_RANGE-1:0]     in_tbi_en,
    input  logic                     in_zero_exempt,
    input  logic [NUM_LVL*CTL_W-1:0] in_ctl,
    input  logic                     in_tag_hit,
    input  logic [TAG_W-1:0]         in_mem_tag,
    input  logic                     clr_valid,
    input  logic [LVL_W-1:0]         clr_level,
    input  logic [NUM_RANGE-1:0]     clr_mask,
    output logic                     out_valid,
    output logic [ADDR_W-1:0]        out_addr,
    output logic                     out_fault,
    output logic [5:0]               out_fsc,
    output logic [ADDR_W-1:0]        out_far,
    output logic [FLAG_W-1:0]        async_flags
);
    decode_t     dec;
    fault_mode_e mode;
    logic        sync_fault, async_set, dual;

    assign dual = (in_level < LVL_W'(2));

    tag_ptr_decode u_decode (
        .ptr    (in_ptr),
        .dual   (dual),
        .tbi_en (in_tbi_en),
        .dec    (dec)
    );

    tag_fault_policy #(.NUM_LVL(NUM_LVL), .CTL_W(CTL_W)) u_policy (
        .level       (in_level),
        .ctl         (in_ctl),
        .strip       (dec.strip),
        .ptag        (dec.ptag),
        .zero_exempt (in_zero_exempt),
        .tag_hit     (in_tag_hit),
        .mem_tag     (in_mem_tag),
        .mode        (mode),
        .sync_fault  (sync_fault),
        .async_set   (async_set)
    );

    tag_async_status #(.NUM_LVL(NUM_LVL)) u_status (
        .clk       (clk),
        .rst       (rst),
        .set_en    (in_valid && async_set),
        .set_level (in_level),
        .set_sel   (dec.sel),
        .clr_valid (clr_valid),
        .clr_level (clr_level),
        .clr_mask  (clr_mask),
        .flags     (async_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_fault <= 1'b0;
            out_fsc   <= '0;
            out_far   <= '0;
        end else begin
            out_valid <= in_valid;
            out_fault <= in_valid && sync_fault;
            out_fsc   <= (in_valid && sync_fault) ? FSC_TAG : '0;
            out_far   <= (in_valid && sync_fault) ? in_ptr : '0;
            if (in_valid) out_addr <= dec.clean;
        end
    end

    // R11
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R11
    fault_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> out_valid);
    // R8
    fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> (out_fsc == 6'h11));
    // R3
    no_storage_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_tag_hit) |=> !out_fault);
    // R4
    high_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_level >= LVL_W'(2)) |=> (out_addr[ADDR_W-1:TAG_LSB] == '0));
    // R6
    low_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_level < LVL_W'(2) && in_tbi_en[in_ptr[CARRY_BIT]])
        |=> (out_addr[ADDR_W-1:TAG_LSB] == {(ADDR_W-TAG_LSB){$past(in_ptr[CARRY_BIT])}}));
endmodule

// File: tb/tag_check_unit_tb.sv
module tag_check_unit_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, in_zero_exempt, in_tag_hit, clr_valid;
    logic [63:0]  in_ptr;
    logic [1:0]   in_level, in_tbi_en, clr_level, clr_mask;
    logic [255:0] in_ctl;
    logic [3:0]   in_mem_tag;
    logic         out_valid, out_fault;
    logic [63:0]  out_addr, out_far;
    logic [5:0]   out_fsc;
    logic [7:0]   async_flags;
    logic [7:0]   exp_flags;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    tag_check_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ptr(in_ptr),
        .in_level(in_level), .in_tbi_en(in_tbi_en), .in_zero_exempt(in_zero_exempt),
        .in_ctl(in_ctl), .in_tag_hit(in_tag_hit), .in_mem_tag(in_mem_tag),
        .clr_valid(clr_valid), .clr_level(clr_level), .clr_mask(clr_mask),
        .out_valid(out_valid), .out_addr(out_addr), .out_fault(out_fault),
        .out_fsc(out_fsc), .out_far(out_far), .async_flags(async_flags)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_tag(input logic [63:0] p);
        logic [63:0] s;
        s = p + (64'h1 << 55);
        return s[59:56];
    endfunction

    // mode at levels 1..3 in [41:40]; level 0 reads level 1 word [39:38]
    task automatic set_mode(input int lvl, input logic [1:0] m);
        if (lvl == 0) in_ctl[64 + 38 +: 2] = m;
        else          in_ctl[lvl*64 + 40 +: 2] = m;
    endtask

    task automatic issue(input logic [63:0] p, input logic [1:0] lvl, input logic [1:0] tbi,
                         input logic zx, input logic hit, input logic [3:0] mt);
        @(negedge clk);
        in_valid = 1'b1; in_ptr = p; in_level = lvl; in_tbi_en = tbi;
        in_zero_exempt = zx; in_tag_hit = hit; in_mem_tag = mt;
        @(negedge clk);
        in_valid = 1'b0; clr_valid = 1'b0;
    endtask

    task automatic expect_no_action(input string req, input logic [63:0] addr);
        chk(req, {63'd0, out_valid}, 64'd1);
        chk(req, {63'd0, out_fault}, 64'd0);
        chk(req, out_addr, addr);
        chk(req, {56'd0, async_flags}, {56'd0, exp_flags});
    endtask

    task automatic t_reset;
        chk("R11 reset valid", {63'd0, out_valid}, 64'd0);
        chk("R9 reset flags", {56'd0, async_flags}, 64'd0);
    endtask

    task automatic t_carry;
        logic [63:0] p;
        set_mode(2, 2'd1);
        p = 64'h0F80_0000_0000_1234;
        chk("R1 ref wrap", {60'd0, ref_tag(p)}, 64'd0);
        issue(p, 2'd2, 2'b00, 1'b0, 1'b1, 4'h0);
        expect_no_action("R1 wrap match", 64'h0080_0000_0000_1234);
        p = 64'h0380_0000_0000_0040;
        issue(p, 2'd2, 2'b00, 1'b0, 1'b1, 4'h3);
        chk("R1 carry mismatch", {63'd0, out_fault}, 64'd1);
        issue(p, 2'd2, 2'b00, 1'b0, 1'b1, 4'h4);
        chk("R1 carry match", {63'd0, out_fault}, 64'd0);
    endtask

    task automatic t_zero_exempt;
        set_mode(3, 2'd1);
        issue(64'h0000_0000_0000_0100, 2'd3, 2'b00, 1'b1, 1'b1, 4'h9);
        expect_no_action("R2 exempt", 64'h0000_0000_0000_0100);
        issue(64'h0000_0000_0000_0100, 2'd3, 2'b00, 1'b0, 1'b1, 4'h9);
        chk("R2 not exempt", {63'd0, out_fault}, 64'd1);
    endtask

    task automatic t_no_storage;
        issue(64'h0500_0000_0000_0200, 2'd3, 2'b00, 1'b0, 1'b0, 4'h1);
        expect_no_action("R3 no storage", 64'h0000_0000_0000_0200);
    endtask

    task automatic t_single_range;
        set_mode(3, 2'd2);
        issue(64'hA2C0_0000_0000_0008, 2'd3, 2'b00, 1'b0, 1'b1, 4'h0);
        exp_flags[6] = 1'b1;
        chk("R4 zext", out_addr, 64'h00C0_0000_0000_0008);
        chk("R4 range0 flag", {56'd0, async_flags}, {56'd0, exp_flags});
    endtask

    task automatic t_tbi_off;
        set_mode(1, 2'd1);
        issue(64'h7A80_0000_0000_0010, 2'd1, 2'b01, 1'b0, 1'b1, 4'h0);
        expect_no_action("R5 range1 off", 64'h7A80_0000_0000_0010);
        issue(64'h7A00_0000_0000_0010, 2'd1, 2'b10, 1'b0, 1'b1, 4'h0);
        expect_no_action("R5 range0 off", 64'h7A00_0000_0000_0010);
    endtask

    task automatic t_sext;
        set_mode(1, 2'd0);
        issue(64'h5A80_0000_0000_0020, 2'd1, 2'b10, 1'b0, 1'b1, 4'h0);
        chk("R6 sext high", out_addr, 64'hFF80_0000_0000_0020);
        issue(64'hA500_0000_0000_0020, 2'd1, 2'b01, 1'b0, 1'b1, 4'h0);
        chk("R6 sext low", out_addr, 64'h0000_0000_0000_0020);
        chk("R10 mode0 no fault", {63'd0, out_fault}, 64'd0);
    endtask

    task automatic t_mode_source;
        set_mode(1, 2'd0);
        set_mode(0, 2'd1);
        issue(64'h0200_0000_0000_0030, 2'd0, 2'b01, 1'b0, 1'b1, 4'h5);
        chk("R7 level0 uses 39:38", {63'd0, out_fault}, 64'd1);
        issue(64'h0200_0000_0000_0030, 2'd1, 2'b01, 1'b0, 1'b1, 4'h5);
        chk("R7 level1 uses 41:40", {63'd0, out_fault}, 64'd0);
    endtask

    task automatic t_sync_fault;
        set_mode(1, 2'd1);
        issue(64'h0680_0000_0000_0044, 2'd1, 2'b10, 1'b0, 1'b1, 4'h2);
        chk("R8 fault", {63'd0, out_fault}, 64'd1);
        chk("R8 fsc", {58'd0, out_fsc}, 64'h11);
        chk("R8 far", out_far, 64'h0680_0000_0000_0044);
        chk("R8 addr", out_addr, 64'hFF80_0000_0000_0044);
        @(negedge clk);
        chk("R8 pulse", {63'd0, out_fault}, 64'd0);
        chk("R8 fsc clear", {58'd0, out_fsc}, 64'd0);
        chk("R8 far clear", out_far, 64'd0);
    endtask

    task automatic t_async;
        set_mode(1, 2'd2);
        issue(64'h0980_0000_0000_0050, 2'd1, 2'b11, 1'b0, 1'b1, 4'h0);
        exp_flags[3] = 1'b1;
        chk("R9 level1 range1", {56'd0, async_flags}, {56'd0, exp_flags});
        chk("R9 no fault", {63'd0, out_fault}, 64'd0);
        set_mode(0, 2'd2);
        issue(64'h0900_0000_0000_0050, 2'd0, 2'b11, 1'b0, 1'b1, 4'h0);
        exp_flags[0] = 1'b1;
        chk("R9 level0 range0", {56'd0, async_flags}, {56'd0, exp_flags});
    endtask

    task automatic t_mode3;
        set_mode(2, 2'd3);
        issue(64'h0700_0000_0000_0060, 2'd2, 2'b00, 1'b0, 1'b1, 4'h1);
        expect_no_action("R10 mode3", 64'h0000_0000_0000_0060);
    endtask

    task automatic t_latency;
        @(negedge clk);
        chk("R11 idle valid", {63'd0, out_valid}, 64'd0);
    endtask

    task automatic t_clear;
        set_mode(1, 2'd2);
        @(negedge clk);
        clr_valid = 1'b1; clr_level = 2'd1; clr_mask = 2'b10;
        issue(64'h0980_0000_0000_0070, 2'd1, 2'b11, 1'b0, 1'b1, 4'h0);
        chk("R12 set wins", {56'd0, async_flags}, {56'd0, exp_flags});
        @(negedge clk);
        clr_valid = 1'b1; clr_level = 2'd1; clr_mask = 2'b11;
        @(negedge clk);
        clr_valid = 1'b0;
        exp_flags[3] = 1'b0;
        chk("R12 clear", {56'd0, async_flags}, {56'd0, exp_flags});
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_ptr = '0; in_level = '0; in_tbi_en = '0;
        in_zero_exempt = 1'b0; in_ctl = '0; in_tag_hit = 1'b0; in_mem_tag = '0;
        clr_valid = 1'b0; clr_level = '0; clr_mask = '0; exp_flags = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_carry();
        t_zero_exempt();
        t_no_storage();
        t_single_range();
        t_tbi_off();
        t_sext();
        t_mode_source();
        t_sync_fault();
        t_async();
        t_mode3();
        t_latency();
        t_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule